// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target-side protocol engine of a two-wire serial memory. It runs on a fast system clock and oversamples SCL and SDA after synchronizing them. It finds start and stop conditions, takes in the address byte and compares it with a fixed prefix and three strap inputs. It acknowledges bytes and steers the transaction against a memory-side port made of an address, a write strobe with write data, and read data.

A write carries a word address and then any number of data bytes. Each data byte is written through the port, and the low three bits of the word pointer advance so that the pointer stays inside its 8-byte page. A read returns the byte at the current pointer, MSB first. It continues with the next address, wrapping over the whole space, for as long as the controller acknowledges. A random read is a write that stops after the word address, followed by a repeated start and a read address byte. SDA is only ever pulled low, through an output-enable. The storage array, the write-cycle timer and input filtering are outside the block. The timer reports through `busy_i`.

Top module: `twi_mem_target`

## Requirements
- R1: While reset is held and in the cycle after it, `sda_oe_o` is 0 and `mem_addr_o` is 0.
- R2: The address byte arrives MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `strap_i[2:0]`, and bit 0 selects the direction (1 read, 0 write). A byte that does not match is not acknowledged, and the engine ignores the bus until the next start: later bytes get no acknowledge and cause no write.
- R3: While `busy_i` is 1, a matching address byte is not acknowledged.
- R4: In a write, the byte after the address byte loads the word pointer. Each later byte is acknowledged (SDA low during the ninth clock) and written to the pointer address with a single-cycle `mem_we_o` pulse.
- R5: After each written byte the pointer's low three bits increment modulo 8 and its upper bits are kept, so that writes wrap inside the same 8-byte page.
- R6: A read address byte with no word address before it returns the byte at the current pointer. The pointer is the last accessed address plus one.
- R7: A write that carries only a word address, followed by a repeated start and a read address byte, returns the byte stored at that word address.
- R8: While the controller acknowledges read bytes, the engine sends the next address's byte. The pointer wraps from the highest address to 0.
- R9: A read byte that the controller does not acknowledge ends the transfer. The engine then drives nothing until the next start.
- R10: A start in any state abandons the current transaction without writing a partial byte and restarts address reception.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Strap bits the address byte must match |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr_o | output | AW | Word pointer, used as the memory address |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte stored at `mem_addr_o` |

## Verification
A wrong bit count or a wrong state shows up at the bus within one byte. An acknowledge appears at the wrong clock, or goes missing, and the controller sees a read byte shifted or mangled on the next nine SCL periods. A pointer fault is silent until the next access. It then shows as the wrong byte in a current-address read, or as a write landing outside its page. The bench therefore reads back every region it writes, and it crosses the page and address-space boundaries. A stale transaction that a start failed to clear shows as an acknowledge to the next address byte, or its absence.

// File: rtl/twi_mem_pkg.sv
// Shared constants and state type for the two-wire memory target.
// Assumes bytes are eight bits and the address prefix is fixed.
package twi_mem_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Multi-flop synchronizer for one bus line. It also gives the previous synchronized value
// for edge detection. Resets to the idle-high bus level. Assumes STAGES >= 2.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic prev_o
);
    logic [STAGES:0] pipe;

    // Shift the raw line through the chain; the extra stage holds the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], d_i};
    end

    assign q_o    = pipe[STAGES-1];
    assign prev_o = pipe[STAGES];
endmodule

// File: rtl/twi_word_ptr.sv
// Word pointer. It loads from the word address byte, steps within a page after a write,
// and steps over the whole space after a read. Assumes PW < AW.
module twi_word_ptr #(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_page_i,
    input  logic          step_all_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    // Update the pointer; a load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr_q <= '0;
        else if (load_i)      ptr_q <= load_val_i;
        else if (step_page_i) ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
        else if (step_all_i)  ptr_q <= ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/twi_mem_target.sv
// Two-wire serial memory target engine. It oversamples SCL and SDA, frames bytes,
// acknowledges them and sequences write, current, random and sequential reads
// against a memory port.
// Assumes: clk is at least 8x the SCL rate; mem_rdata_i is valid within a few clocks
// of a mem_addr_o change; SDA is wired open-drain outside the block.
module twi_mem_target
    import twi_mem_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    output logic               sda_oe_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic               mem_we_o,
    output logic [BYTE_W-1:0]  mem_wdata_o,
    input  logic [BYTE_W-1:0]  mem_rdata_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    logic [1:0] raw_lines, sync_lines, prev_lines;
    logic scl_s, scl_p, sda_s, sda_p;
    logic start_evt, stop_evt, scl_rise, scl_fall;

    twi_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q, oe_q, we_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              byte_done, addr_hit;
    logic              ptr_load, ptr_page, ptr_all;
    logic [AW-1:0]     ptr;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw_lines[g]),
            .q_o    (sync_lines[g]),
            .prev_o (prev_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign scl_p = prev_lines[0];
    assign sda_s = sync_lines[1];
    assign sda_p = prev_lines[1];

    // Bus events: SDA edges while SCL is high frame a transaction, SCL edges move bits.
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;

    assign byte_done = (bitcnt == FULL_CNT);
    assign addr_hit  = (shreg[BYTE_W-1 -: 4] == DEV_PREFIX) &&
                       (shreg[STRAP_W:1] == strap_i) && !busy_i;

    // Pointer control: load on word-address accept, page step after a write, full step after a read byte.
    always_comb begin
        ptr_load = scl_fall && byte_done && (state == ST_WADR);
        ptr_page = we_q;
        ptr_all  = scl_fall && byte_done && (state == ST_RDAT);
    end

    twi_word_ptr #(.AW(AW), .PW(PW)) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ptr_load),
        .load_val_i  (shreg[AW-1:0]),
        .step_page_i (ptr_page),
        .step_all_i  (ptr_all),
        .ptr_o       (ptr)
    );

    // Transaction state machine: bit shifting, acknowledge drive and read data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            rw_q    <= 1'b0;
            oe_q    <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= 1'b0;
            if (start_evt) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                oe_q   <= 1'b0;
            end else if (stop_evt) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && byte_done) begin
                            if (state == ST_DEV) begin
                                if (addr_hit) begin
                                    oe_q  <= 1'b1;
                                    rw_q  <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADR) begin
                                oe_q  <= 1'b1;
                                state <= ST_WADR_ACK;
                            end else begin
                                oe_q    <= 1'b1;
                                we_q    <= 1'b1;
                                wdata_q <= shreg;
                                state   <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            oe_q   <= 1'b0;
                            if (state == ST_DEV_ACK && rw_q) begin
                                shreg <= mem_rdata_i;
                                oe_q  <= ~mem_rdata_i[BYTE_W-1];
                                state <= ST_RDAT;
                            end else if (state == ST_DEV_ACK) begin
                                state <= ST_WADR;
                            end else begin
                                state <= ST_WDAT;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_done) begin
                                oe_q  <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                                oe_q  <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            shreg  <= mem_rdata_i;
                            oe_q   <= ~mem_rdata_i[BYTE_W-1];
                            state  <= ST_RDAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o    = oe_q;
    assign mem_addr_o  = ptr;
    assign mem_we_o    = we_q;
    assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/twi_mem_target_chk.sv
// Assertion checker for the two-wire memory target, attached by bind.
// Assumes the bus environment keeps SCL low for several clocks around SDA changes.
module twi_mem_target_chk
    import twi_mem_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          start_evt,
    input twi_state_e    state
);
    // R1: reset leaves the line released and the pointer at zero
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe_o && mem_addr_o == '0));

    // R11: the drive changes only while SCL is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R4: every written byte is acknowledged
    assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> sda_oe_o);

    // R5: the pointer step after a write stays in the page
    assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_addr_o[AW-1:PW] == $past(mem_addr_o[AW-1:PW])));

    // R10: a start always restarts address reception
    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_DEV));
endmodule

bind twi_mem_target twi_mem_target_chk #(.AW(AW), .PW(PW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .start_evt  (start_evt),
    .state      (state)
);

// File: tb/twi_mem_target_tb.sv
// Bench: a behavioural bus controller, a memory stand-in and a reference memory model.
module twi_mem_target_tb_top;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic busy = 1'b0;
    logic sda_oe, mem_we;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic sda_line;

    logic [7:0] dut_mem [256];
    logic [7:0] model_mem [256];
    int n_tests = 0, n_fail = 0, we_count = 0, r11_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line  = sda_drv & ~sda_oe;
    assign mem_rdata = dut_mem[mem_addr];

    twi_mem_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .strap_i(strap), .busy_i(busy), .sda_oe_o(sda_oe),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    // Memory stand-in on the memory-side port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dut_mem[i] <= 8'(i) ^ 8'h3C;
        end else if (mem_we) begin
            dut_mem[mem_addr] <= mem_wdata;
            we_count <= we_count + 1;
        end
    end

    // Per-clock R11 compare: drive must stay put while SCL is held high
    logic last_scl = 1'b1, last_oe = 1'b0;
    always begin
        @(posedge clk); #1;
        if (rst_n && scl_drv && last_scl && (sda_oe !== last_oe)) r11_err++;
        last_scl = scl_drv;
        last_oe  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_cond;
        @(negedge clk) sda_drv = 1'b1;
        repeat (H) @(negedge clk);
        scl_drv = 1'b1;
        repeat (H) @(negedge clk);
        sda_drv = 1'b0;
        repeat (H) @(negedge clk);
        scl_drv = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic stop_cond;
        @(negedge clk) sda_drv = 1'b0;
        repeat (H) @(negedge clk);
        scl_drv = 1'b1;
        repeat (H) @(negedge clk);
        sda_drv = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        @(negedge clk) sda_drv = b;
        repeat (H) @(negedge clk);
        scl_drv = 1'b1;
        repeat (H/2) @(negedge clk);
        seen = sda_line;
        repeat (H/2) @(negedge clk);
        scl_drv = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(v[i], s);
        send_bit(1'b1, ack_n);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            v[i] = s;
        end
        send_bit(~give_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int wc;
        for (int i = 0; i < 256; i++) model_mem[i] = 8'(i) ^ 8'h3C;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 pointer after reset", mem_addr, 0);
        repeat (4) @(negedge clk);

        // R4: byte write of 5A at 10
        start_cond();
        write_byte(8'hAA, a); chk("R4 address ack", a, 0);
        write_byte(8'h10, a); chk("R4 word address ack", a, 0);
        write_byte(8'h5A, a); chk("R4 data ack", a, 0);
        stop_cond();
        model_mem[8'h10] = 8'h5A;
        chk("R4 byte stored", dut_mem[8'h10], 8'h5A);
        chk("R5 pointer after byte write", mem_addr, 8'h11);

        // R3: busy blocks the address acknowledge
        busy = 1'b1;
        start_cond();
        write_byte(8'hAA, a); chk("R3 no ack while busy", a, 1);
        stop_cond();
        busy = 1'b0;

        // R2: strap mismatch and wrong prefix
        wc = we_count;
        start_cond();
        write_byte(8'hA4, a); chk("R2 strap mismatch no ack", a, 1);
        write_byte(8'h20, a); chk("R2 later byte ignored", a, 1);
        write_byte(8'h77, a); chk("R2 data ignored", a, 1);
        stop_cond();
        start_cond();
        write_byte(8'hBA, a); chk("R2 prefix mismatch no ack", a, 1);
        stop_cond();
        chk("R2 no write on mismatch", we_count, wc);
        chk("R2 pointer unchanged", mem_addr, 8'h11);

        // R5: page write from 1D wraps to 18
        start_cond();
        write_byte(8'hAA, a);
        write_byte(8'h1D, a); chk("R5 word address ack", a, 0);
        for (int k = 0; k < 5; k++) begin
            write_byte(8'hC0 + 8'(k), a);
            chk("R5 page data ack", a, 0);
            model_mem[{5'h03, 3'(5 + k)}] = 8'hC0 + 8'(k);
        end
        stop_cond();
        for (int k = 8'h18; k < 8'h20; k++)
            chk("R5 page contents", dut_mem[k], model_mem[k]);
        chk("R5 next in page", mem_addr, 8'h1A);

        // R6: current address read at 1A
        start_cond();
        write_byte(8'hAB, a); chk("R6 read address ack", a, 0);
        read_byte(1'b0, d); chk("R6 current read data", d, model_mem[8'h1A]);
        stop_cond();
        chk("R6 pointer after read", mem_addr, 8'h1B);

        // R7: random read at 18
        start_cond();
        write_byte(8'hAA, a);
        write_byte(8'h18, a); chk("R7 dummy write ack", a, 0);
        start_cond();
        write_byte(8'hAB, a); chk("R7 repeated start ack", a, 0);
        read_byte(1'b0, d); chk("R7 random read data", d, model_mem[8'h18]);
        stop_cond();

        // R8: sequential read across the top of the space; R9 at its end
        start_cond();
        write_byte(8'hAA, a);
        write_byte(8'hFE, a);
        start_cond();
        write_byte(8'hAB, a);
        read_byte(1'b1, d); chk("R8 seq byte FE", d, model_mem[8'hFE]);
        read_byte(1'b1, d); chk("R8 seq byte FF", d, model_mem[8'hFF]);
        read_byte(1'b0, d); chk("R8 seq wrap to 00", d, model_mem[8'h00]);
        read_byte(1'b0, d); chk("R9 nothing driven after no ack", d, 8'hFF);
        chk("R9 line released", sda_oe, 0);
        stop_cond();

        // R10: start mid data byte abandons the write
        wc = we_count;
        start_cond();
        write_byte(8'hAA, a);
        write_byte(8'h40, a); chk("R10 word address ack", a, 0);
        send_bit(1'b1, a); send_bit(1'b0, a); send_bit(1'b1, a); send_bit(1'b0, a);
        start_cond();
        write_byte(8'hAB, a); chk("R10 address after abort ack", a, 0);
        read_byte(1'b0, d); chk("R10 read at loaded pointer", d, model_mem[8'h40]);
        stop_cond();
        chk("R10 no partial write", we_count, wc);

        chk("R11 drive stable while SCL high", r11_err, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule